// File: doc/BRIEF.md
# Serial Gain Word Receiver

This block is the digital control side of a programmable-gain amplifier. A host shifts an 8-bit gain code in over three wires: a serial clock, a serial data line and an active-low load enable. The block samples all three in a fast system clock domain. Each wire passes through a two-flop synchronizer, and edges are found on the synchronized copies.

While the enable is high, the block is in state HOLD. Serial clocking is ignored and the applied gain code stays constant. A falling enable (transition OPEN) moves the block to state LOAD and resets the bit counter. In LOAD, a rising serial clock latches the data line into a master stage. The following falling serial clock shifts the master bit into an 8-bit slave register, most significant bit first. A rising enable (transition COMMIT) copies the slave register into the applied gain register and returns to HOLD. The previous gain therefore stays in force for the whole load.

The applied code is decoded into a gain step index (0 to 71, 0.7526 dB per step, 0 being the minimum gain) and a saturation flag. An active-low power-down input is synchronized and appears as an amplifier-enable output.

Top module: `gain_word_rx`

## Requirements
- R1: While reset is asserted and after its release, gain_code is 0, step_idx is 0, gain_sat is 0, short_word is 0 and amp_en is 0, until inputs change.
- R2: A word shifted with 8 serial clock pulses in LOAD is committed on the rising enable with the first bit shifted landing in bit 7 (MSB first); the master bit is captured on the rising serial clock and shifted on the falling one.
- R3: gain_code does not change while the enable is low or between loads; it changes only at a COMMIT.
- R4: Serial clock pulses while the enable is high do not enter the slave register; this is visible at the next short commit.
- R5: The slave register is not cleared on OPEN. A COMMIT after n<8 falling clocks applies (old_word << n) | new_bits, truncated to 8 bits, and pulses short_word for exactly one cycle. With 8 or more falling clocks, the last 8 bits are applied and short_word stays 0.
- R6: For codes 0 to 71, step_idx equals the code and gain_sat is 0.
- R7: For codes 72 to 127 and 200 to 255, step_idx is 71 and gain_sat is 1.
- R8: For codes 128 to 199, step_idx is code minus 128 (71 minus (199 minus code)) and gain_sat is 0.
- R9: amp_en follows pd_n through a two-stage synchronizer: 0 on pd_n disables the amplifier and 1 enables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock from the host |
| ser_data | input | 1 | Serial gain data, MSB first |
| load_en_n | input | 1 | Active-low load enable; rising edge applies the word |
| pd_n | input | 1 | Active-low power-down request |
| gain_code | output | 8 | Applied gain code |
| step_idx | output | 7 | Decoded gain step, 0 to 71 |
| gain_sat | output | 1 | Code lies in a range held at maximum gain |
| short_word | output | 1 | One-cycle pulse: last commit had fewer than 8 bits |
| amp_en | output | 1 | Forward amplifier enable |

## Verification
The assertions assume that a serial clock edge and an enable edge never reach the synchronized domain in the same system cycle. They also assume that the data line is stable over each rising serial clock. The stimulus keeps every serial half-period and every enable change at least four system cycles apart. It changes data only while the serial clock is low. Under those conditions, the hold, shift-freeze and single-cycle short-flag properties describe the block exactly.

// File: rtl/gwr_pkg.sv
`timescale 1ns/1ps
package gwr_pkg;
    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_LOAD = 1'b1
    } ld_state_t;

    // synchronized input vector positions
    localparam int IDX_SCLK = 0;
    localparam int IDX_SDAT = 1;
    localparam int IDX_EN   = 2;
    localparam int IDX_PD   = 3;
    localparam int IN_W     = 4;
endpackage

// File: rtl/gwr_sync.sv
`timescale 1ns/1ps
module gwr_sync #(
    parameter int         W       = 4,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gwr_edges.sv
`timescale 1ns/1ps
module gwr_edges #(
    parameter int         W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/gwr_fsm.sv
`timescale 1ns/1ps
module gwr_fsm
    import gwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_rise,
    input  logic      en_fall,
    output logic      shift_on,
    output logic      open_stb,
    output logic      commit_stb,
    output ld_state_t state_o
);
    ld_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        open_stb   = 1'b0;
        commit_stb = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                if (en_fall) begin
                    state_d  = ST_LOAD;
                    open_stb = 1'b1;
                end
            end
            ST_LOAD: begin
                if (en_rise) begin
                    state_d    = ST_HOLD;
                    commit_stb = 1'b1;
                end
            end
            default: state_d = ST_HOLD;
        endcase
    end

    assign shift_on = (state_q == ST_LOAD);
    assign state_o  = state_q;
endmodule

// File: rtl/gwr_shift.sv
`timescale 1ns/1ps
module gwr_shift #(
    parameter int WORD_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_on,
    input  logic              open_stb,
    input  logic              clk_rise,
    input  logic              clk_fall,
    input  logic              data_bit,
    output logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  bits_seen
);
    logic              master_q;
    logic [WORD_W-1:0] slave_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_q <= 1'b0;
            slave_q  <= '0;
            cnt_q    <= '0;
        end else begin
            if (open_stb) begin
                cnt_q <= '0;
            end else if (shift_on && clk_fall && (cnt_q != CNT_W'(WORD_W))) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (shift_on && clk_rise) master_q <= data_bit;
            if (shift_on && clk_fall) slave_q  <= {slave_q[WORD_W-2:0], master_q};
        end
    end

    assign word      = slave_q;
    assign bits_seen = cnt_q;

    // R4: the slave register is frozen outside LOAD
    a_r4_frozen_outside_load: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_on |=> $stable(slave_q));

    // R5: the bit counter saturates at the word length
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(WORD_W));
endmodule

// File: rtl/gwr_decode.sv
`timescale 1ns/1ps
module gwr_decode #(
    parameter int WORD_W   = 8,
    parameter int STEP_W   = 7,
    parameter int STEP_TOP = 71,
    parameter int FOLD_LO  = 128,
    parameter int FOLD_HI  = 199
) (
    input  logic [WORD_W-1:0] code,
    output logic [STEP_W-1:0] step,
    output logic              sat
);
    int ci;
    int si;

    always_comb begin
        ci  = int'(code);
        si  = STEP_TOP;
        sat = 1'b1;
        if (ci <= STEP_TOP) begin
            si  = ci;
            sat = 1'b0;
        end else if ((ci >= FOLD_LO) && (ci <= FOLD_HI)) begin
            si  = STEP_TOP - (FOLD_HI - ci);
            sat = 1'b0;
        end
        step = STEP_W'(si);
    end

    always_comb begin
        // R7: a saturated code always maps to the top step
        a_r7_sat_top: assert (!sat || (int'(step) == STEP_TOP));
        // R6: the step index never exceeds the top step
        a_r6_step_range: assert (int'(step) <= STEP_TOP);
    end
endmodule

// File: rtl/gain_word_rx.sv
`timescale 1ns/1ps
module gain_word_rx
    import gwr_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int STEP_W      = 7,
    parameter int STEP_TOP    = 71,
    parameter int FOLD_LO     = 128,
    parameter int FOLD_HI     = 199,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              load_en_n,
    input  logic              pd_n,
    output logic [WORD_W-1:0] gain_code,
    output logic [STEP_W-1:0] step_idx,
    output logic              gain_sat,
    output logic              short_word,
    output logic              amp_en
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [IN_W-1:0] SYNC_RST = 4'b0100;  // enable idles high

    logic [IN_W-1:0]  raw_in, syn;
    logic [1:0]       rise_v, fall_v;
    logic             shift_on, open_stb, commit_stb;
    ld_state_t        state;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  bits_seen;
    logic [WORD_W-1:0] gain_q;
    logic              short_q;

    assign raw_in = {pd_n, load_en_n, ser_data, ser_clk};

    gwr_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
    );

    gwr_edges #(.W(2), .RST_VAL(2'b10)) u_edges (
        .clk(clk), .rst_n(rst_n),
        .lvl({syn[IDX_EN], syn[IDX_SCLK]}),
        .rise(rise_v), .fall(fall_v)
    );

    gwr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .en_rise(rise_v[1]), .en_fall(fall_v[1]),
        .shift_on(shift_on), .open_stb(open_stb), .commit_stb(commit_stb),
        .state_o(state)
    );

    gwr_shift #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .shift_on(shift_on), .open_stb(open_stb),
        .clk_rise(rise_v[0]), .clk_fall(fall_v[0]),
        .data_bit(syn[IDX_SDAT]),
        .word(word), .bits_seen(bits_seen)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_q  <= '0;
            short_q <= 1'b0;
        end else begin
            if (commit_stb) gain_q <= word;
            short_q <= commit_stb && (bits_seen < CNT_W'(WORD_W));
        end
    end

    gwr_decode #(
        .WORD_W(WORD_W), .STEP_W(STEP_W), .STEP_TOP(STEP_TOP),
        .FOLD_LO(FOLD_LO), .FOLD_HI(FOLD_HI)
    ) u_dec (
        .code(gain_q), .step(step_idx), .sat(gain_sat)
    );

    assign gain_code  = gain_q;
    assign short_word = short_q;
    assign amp_en     = syn[IDX_PD];

    // R3: applied gain moves only on a commit
    a_r3_gain_held: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_stb |=> $stable(gain_q));

    // R3: a steadily high enable means the block is in HOLD
    a_r3_hold_when_enable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (syn[IDX_EN] && $past(syn[IDX_EN])) |-> (state == ST_HOLD));

    // R5: the short-word flag lasts a single cycle
    a_r5_short_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        short_q |=> !short_q);
endmodule

// File: tb/gain_word_rx_test.sv
`timescale 1ns/1ps
module gain_word_rx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, load_en_n = 1'b1, pd_n = 1'b0;
    logic [7:0] gain_code;
    logic [6:0] step_idx;
    logic       gain_sat, short_word, amp_en;

    int n_cmp = 0;
    int n_bad = 0;
    int short_hits = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    gain_word_rx uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .load_en_n(load_en_n), .pd_n(pd_n), .gain_code(gain_code),
        .step_idx(step_idx), .gain_sat(gain_sat), .short_word(short_word),
        .amp_en(amp_en)
    );

    function automatic int exp_step(int c);
        if (c <= 71) return c;
        if (c >= 128 && c <= 199) return 71 - (199 - c);
        return 71;
    endfunction

    function automatic bit exp_sat(int c);
        return !((c <= 71) || (c >= 128 && c <= 199));
    endfunction

    function automatic string dec_tag(int c);
        if (c <= 71) return "R6";
        if (c >= 128 && c <= 199) return "R8";
        return "R7";
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: input history, level edges, load state
    logic [3:0] h1, h2, h3;
    bit   m_load, m_master, m_short;
    logic [7:0] m_shreg, m_gain;
    int   m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h1 = 4'b0100; h2 = 4'b0100; h3 = 4'b0100;
            m_load = 0; m_master = 0; m_short = 0;
            m_shreg = 8'h00; m_gain = 8'h00; m_cnt = 0;
        end else begin
            logic [3:0] rv, fv;
            rv = h2 & ~h3;
            fv = ~h2 & h3;
            m_short = 0;
            if (!m_load) begin
                if (fv[2]) begin m_load = 1; m_cnt = 0; end
            end else begin
                if (rv[2]) begin
                    m_gain = m_shreg; m_short = (m_cnt < 8); m_load = 0;
                end
                if (rv[0]) m_master = h2[1];
                if (fv[0]) begin
                    m_shreg = {m_shreg[6:0], m_master};
                    if (m_cnt < 8) m_cnt++;
                end
            end
            h3 = h2; h2 = h1; h1 = {pd_n, load_en_n, ser_data, ser_clk};
        end
    end

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 gain_code vs model", int'(gain_code), int'(m_gain));
            check({dec_tag(int'(gain_code)), " step_idx"}, int'(step_idx), exp_step(int'(m_gain)));
            check({dec_tag(int'(gain_code)), " gain_sat"}, int'(gain_sat), int'(exp_sat(int'(m_gain))));
            check("R5 short_word vs model", int'(short_word), int'(m_short));
            check("R9 amp_en vs model", int'(amp_en), int'(h2[3]));
            if (short_word) short_hits++;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(logic [15:0] w, int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = w[i];
            wait_cyc(4);
            ser_clk = 1'b1;
            wait_cyc(4);
            ser_clk = 1'b0;
            wait_cyc(4);
        end
    endtask

    task automatic open_load();
        load_en_n = 1'b0;
        wait_cyc(5);
    endtask

    task automatic commit_load();
        load_en_n = 1'b1;
        wait_cyc(6);
    endtask

    task automatic full_word(logic [7:0] w);
        open_load();
        send_bits({8'h00, w}, 8);
        commit_load();
    endtask

    task automatic check_code(string tag, int c);
        check({tag, " gain_code"}, int'(gain_code), c);
        check({tag, " step_idx"}, int'(step_idx), exp_step(c));
        check({tag, " gain_sat"}, int'(gain_sat), int'(exp_sat(c)));
    endtask

    initial begin
        // R1: reset state
        wait_cyc(3);
        check("R1 gain_code in reset", int'(gain_code), 0);
        check("R1 amp_en in reset", int'(amp_en), 0);
        rst_n = 1'b1;
        wait_cyc(4);
        check("R1 gain_code after reset", int'(gain_code), 0);
        check("R1 step_idx after reset", int'(step_idx), 0);
        check("R1 gain_sat after reset", int'(gain_sat), 0);
        check("R1 short_word after reset", int'(short_word), 0);
        check("R1 amp_en after reset", int'(amp_en), 0);

        // R2, R6: plain word, MSB first
        full_word(8'd42);
        check_code("R2 R6 code 42", 42);
        check("R5 no short on full word", short_hits, 0);

        // R3: gain held mid-load
        open_load();
        send_bits(16'h000F, 4);
        check("R3 gain held mid-load", int'(gain_code), 42);
        send_bits(16'h0000, 4);
        check("R3 gain held before commit", int'(gain_code), 42);
        commit_load();
        check_code("R7 code 240", 240);

        full_word(8'd100); check_code("R7 code 100", 100);
        full_word(8'd71);  check_code("R6 code 71", 71);
        full_word(8'd72);  check_code("R7 code 72", 72);
        full_word(8'd128); check_code("R8 code 128", 128);
        full_word(8'd155); check_code("R8 code 155", 155);
        full_word(8'd199); check_code("R8 code 199", 199);
        full_word(8'd200); check_code("R7 code 200", 200);
        full_word(8'd0);   check_code("R6 code 0", 0);
        check("R5 no short after full words", short_hits, 0);

        // R4, R5: clocks in HOLD ignored, short word shifts old contents
        full_word(8'hB5);
        ser_data = 1'b1;
        for (int k = 0; k < 3; k++) begin
            ser_clk = 1'b1; wait_cyc(4);
            ser_clk = 1'b0; wait_cyc(4);
        end
        ser_data = 1'b0;
        open_load();
        send_bits(16'h0002, 3);
        commit_load();
        check_code("R4 R5 short commit", 8'hAA);
        check("R5 short pulse count", short_hits, 1);

        // R5: over-length load keeps last 8 bits
        open_load();
        send_bits(16'h033C, 10);
        commit_load();
        check_code("R5 over-length", 8'h3C);
        check("R5 no pulse on over-length", short_hits, 1);

        // R9: power-down pass-through
        pd_n = 1'b1; wait_cyc(3);
        check("R9 amp enabled", int'(amp_en), 1);
        pd_n = 1'b0; wait_cyc(3);
        check("R9 amp disabled", int'(amp_en), 0);
        check("R3 gain untouched by pd", int'(gain_code), 8'h3C);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule